// File: doc/BRIEF.md
# Analog Input Channel-List Sequencer

This block controls the digital side of a 16-channel, 12-bit analog input path. Software fills a channel list with packed entries. Each entry names a channel, a gain step, a polarity and a single-ended or differential input. Software then chooses how conversions are triggered. A conversion drives the current entry's select fields out to an external converter and holds a request until the converter answers. The converter's result is pushed into a result FIFO. After every conversion the list pointer moves to the next entry, and it wraps to the first entry after the last one written.

Four 16-bit registers sit on a simple word bus, and reads return data combinationally.

| Word address | Function |
|---|---|
| 0 | Control register A. Reading it in software-trigger mode starts a conversion. |
| 1 | Control register B, which holds the FIFO enables. |
| 2 | Status. Writing any value clears the latched interrupt causes. |
| 3 | Data. Reads pop the result FIFO; writes append a list entry. |

Clearing a FIFO enable also empties that FIFO. The block raises an interrupt line from the latched causes.

Top module: `aics_seq`

## Requirements
- R1: The register addresses are 0 for control A, 1 for control B, 2 for status and 3 for data. After reset, both control registers read 0 and status reads 0x0004.
- R2: Control A bits 1:0 select the trigger mode: 0 off, 1 software, 2 scan, 3 external. In mode 1 a read of address 0 starts one conversion. In mode 0 no conversion ever starts.
- R3: A list entry is written to address 3. Bit 7 selects differential input, bit 6 selects unipolar range, bits 5:4 are the gain select and bits 3:0 are the channel. While a conversion runs, these fields of the current entry are driven on conv_diff, conv_unipolar, conv_gain and conv_chan.
- R4: conv_req rises in the cycle after a start and stays high until the cycle after conv_done. Status bit 0 reads 1 for that whole time.
- R5: Each finished conversion advances the list pointer. After the last written entry, the pointer wraps to entry 0.
- R6: In mode 3, each ext_trig pulse seen while idle starts exactly one conversion. In mode 2, an ext_trig pulse seen while idle converts entries back to back, from the current entry through the last one, and stops when the pointer wraps.
- R7: Control B bit 10 enables the result FIFO and bit 9 enables the list. While a bit is 0, its FIFO is held empty and data writes to the list are ignored. No conversion starts unless both bits are 1 and the list holds at least one entry.
- R8: A data read returns results in arrival order, with the 12-bit result in bits 11:0 and bits 15:12 at zero. A data read from an empty FIFO returns 0 and leaves the FIFO unchanged.
- R9: The status fields are:
  - bit 4: result FIFO full
  - bit 3: at least half full
  - bit 2: empty
  - bit 1: list full
  - bit 0: conversion active

  A result that arrives while the FIFO is full is dropped. A list write while the list is full is ignored.
- R10: Status bit 8 latches when a result brings the FIFO to exactly half full while control A bit 8 is set. Status bit 9 latches on ext_trig while control A bit 9 is set. Any write to status clears both latched bits, unless a bit is being set in the same cycle. irq is high when control A bit 15 is set and either latched bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (side effects happen at the clock edge) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ext_trig | input | 1 | External trigger pulse |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_chan | output | 4 | Channel of the current entry |
| conv_gain | output | 2 | Gain select of the current entry |
| conv_unipolar | output | 1 | Unipolar range select |
| conv_diff | output | 1 | Differential input select |
| conv_done | input | 1 | Converter response pulse |
| conv_result | input | RES_W (12) | Converter result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the block's inputs:
- conv_done pulses only while conv_req is high.
- Bus strobes last a single cycle and never overlap.
- A reset is followed by configuration writes rather than by free-running triggers.

The bench keeps within these assumptions by driving every bus operation as a one-cycle strobe followed by an idle cycle. Its converter model answers a request only after a fixed latency, and only while the request is held. External trigger pulses are issued when the block is idle, except where the ignore rules themselves are under test.

// File: rtl/aics_seq.sv
module aics_seq #(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16,
  parameter int RES_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             ext_trig,
  output logic             conv_req,
  output logic [3:0]       conv_chan,
  output logic [1:0]       conv_gain,
  output logic             conv_unipolar,
  output logic             conv_diff,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             irq
);
  localparam int LAW = $clog2(LIST_DEPTH);
  localparam int RAW = $clog2(RES_DEPTH);
  localparam logic [LAW:0] LFULL = (LAW+1)'(LIST_DEPTH);
  localparam logic [RAW:0] RFULL = (RAW+1)'(RES_DEPTH);
  localparam logic [RAW:0] RHALF = (RAW+1)'(RES_DEPTH / 2);
  localparam logic [RAW:0] RHALF_M1 = (RAW+1)'(RES_DEPTH / 2 - 1);

  logic [15:0] ctrl1, ctrl2;
  logic [7:0] list_mem [LIST_DEPTH];
  logic [LAW:0] list_cnt;
  logic [LAW-1:0] list_ptr;
  logic [RES_W-1:0] res_mem [RES_DEPTH];
  logic [RAW-1:0] res_wp, res_rp;
  logic [RAW:0] res_cnt;
  logic active, scan_run, flag_hf, flag_ext;

  logic [1:0] mode;
  logic sel_c1, sel_c2, sel_st, sel_dat;
  logic list_on, res_on, res_empty, res_full, list_full;
  logic ext_go, trig, start, finish, wrap, push, pop, lwr;
  logic hf_set, ext_set, st_clr;
  logic [15:0] status;

  assign mode      = ctrl1[1:0];
  assign sel_c1    = bus_addr == 2'd0;
  assign sel_c2    = bus_addr == 2'd1;
  assign sel_st    = bus_addr == 2'd2;
  assign sel_dat   = bus_addr == 2'd3;
  assign list_on   = ctrl2[9];
  assign res_on    = ctrl2[10];
  assign res_empty = res_cnt == '0;
  assign res_full  = res_cnt == RFULL;
  assign list_full = list_cnt == LFULL;

  assign ext_go = ext_trig && mode[1] && !scan_run;
  assign trig   = (mode == 2'd1 && bus_rd && sel_c1) || ext_go || (scan_run && mode == 2'd2);
  assign start  = trig && !active && list_on && res_on && list_cnt != '0;
  assign finish = active && conv_done;
  assign wrap   = ({1'b0, list_ptr} + (LAW+1)'(1)) == list_cnt;
  assign push   = finish && res_on && !res_full;
  assign pop    = bus_rd && sel_dat && !res_empty;
  assign lwr    = bus_wr && sel_dat && list_on && !list_full;
  assign hf_set  = ctrl1[8] && push && !pop && res_cnt == RHALF_M1;
  assign ext_set = ctrl1[9] && ext_trig;
  assign st_clr  = bus_wr && sel_st;

  assign {conv_diff, conv_unipolar, conv_gain, conv_chan} = list_mem[list_ptr];
  assign conv_req = active;
  assign irq      = ctrl1[15] && (flag_hf || flag_ext);
  assign status   = {6'b0, flag_ext, flag_hf, 3'b0, res_full, res_cnt >= RHALF,
                     res_empty, list_full, active};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl1;
      2'd1:    bus_rdata = ctrl2;
      2'd2:    bus_rdata = status;
      default: bus_rdata = res_empty ? 16'h0 : 16'(res_mem[res_rp]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1 <= '0;
      ctrl2 <= '0;
    end else begin
      if (bus_wr && sel_c1) ctrl1 <= bus_wdata;
      if (bus_wr && sel_c2) ctrl2 <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      scan_run <= 1'b0;
    end else begin
      if (finish)     active <= 1'b0;
      else if (start) active <= 1'b1;
      if (!list_on || !res_on || mode != 2'd2) scan_run <= 1'b0;
      else if (finish && wrap)                 scan_run <= 1'b0;
      else if (start && ext_go)                scan_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_cnt <= '0;
      list_ptr <= '0;
    end else if (!list_on) begin
      list_cnt <= '0;
      list_ptr <= '0;
    end else begin
      if (finish) list_ptr <= wrap ? '0 : list_ptr + LAW'(1);
      if (lwr)    list_cnt <= list_cnt + (LAW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (lwr) list_mem[list_cnt[LAW-1:0]] <= bus_wdata[7:0];
    if (push) res_mem[res_wp] <= conv_result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_wp  <= '0;
      res_rp  <= '0;
      res_cnt <= '0;
    end else if (!res_on) begin
      res_wp  <= '0;
      res_rp  <= '0;
      res_cnt <= '0;
    end else begin
      if (push) res_wp <= res_wp + RAW'(1);
      if (pop)  res_rp <= res_rp + RAW'(1);
      res_cnt <= res_cnt + {{RAW{1'b0}}, push} - {{RAW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hf  <= 1'b0;
      flag_ext <= 1'b0;
    end else begin
      flag_hf  <= hf_set || (flag_hf && !st_clr);
      flag_ext <= ext_set || (flag_ext && !st_clr);
    end
  end
endmodule

// File: rtl/aics_seq_chk.sv
module aics_seq_chk #(
  parameter int RES_DEPTH = 16,
  localparam int CW = $clog2(RES_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          ext_trig,
  input logic          conv_req,
  input logic          conv_done,
  input logic          irq,
  input logic [CW-1:0] res_cnt,
  input logic [1:0]    mode
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done |=> conv_req);
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_done |=> !conv_req);
  p_idle_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(mode) != 2'd0);
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd3 && res_cnt == '0 |-> bus_rdata == 16'h0);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_cnt <= CW'(RES_DEPTH));
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd1 && !bus_wdata[10] |=> ##1 res_cnt == '0);
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd2 && !ext_trig && !conv_done |=> !irq);
endmodule

bind aics_seq aics_seq_chk #(.RES_DEPTH(RES_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
  .conv_req(conv_req), .conv_done(conv_done), .irq(irq), .res_cnt(res_cnt),
  .mode(mode)
);

// File: tb/sim_aics_seq.sv
module sim_aics_seq;
  localparam int LD = 16;
  localparam int RD = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic ext_trig = 1'b0;
  logic conv_req, conv_unipolar, conv_diff, conv_done = 1'b0;
  logic [3:0] conv_chan;
  logic [1:0] conv_gain;
  logic [11:0] conv_result = '0;
  logic irq;

  always #2.5 clk = ~clk;

  aics_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_gain(conv_gain),
    .conv_unipolar(conv_unipolar), .conv_diff(conv_diff), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_c1, m_c2;
  logic [7:0] m_list[$];
  int m_res[$];
  int m_ptr;
  bit m_active, m_scan, m_hf, m_ext;
  int md, ols, ors;
  bit lon, ron, ext_ok, trg, st, fin, pu, po, hfs, wrp, clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = '0; m_c2 = '0; m_list.delete(); m_res.delete(); m_ptr = 0;
      m_active = 0; m_scan = 0; m_hf = 0; m_ext = 0;
    end else begin
      md = int'(m_c1[1:0]); lon = m_c2[9]; ron = m_c2[10];
      ols = m_list.size(); ors = m_res.size();
      ext_ok = ext_trig && md >= 2 && !m_scan;
      trg = (md == 1 && bus_rd && bus_addr == 0) || ext_ok || (m_scan && md == 2);
      st = trg && !m_active && lon && ron && ols > 0;
      fin = m_active && conv_done;
      wrp = (m_ptr + 1) == ols;
      po = bus_rd && bus_addr == 3 && ors > 0;
      pu = fin && ron && ors < RD;
      hfs = m_c1[8] && pu && !po && ors == RD / 2 - 1;
      clr = bus_wr && bus_addr == 2;
      if (!ron) m_res.delete();
      else begin
        if (po) void'(m_res.pop_front());
        if (pu) m_res.push_back(int'(conv_result));
      end
      if (!lon) begin m_list.delete(); m_ptr = 0; end
      else begin
        if (fin) m_ptr = wrp ? 0 : m_ptr + 1;
        if (bus_wr && bus_addr == 3 && ols < LD) m_list.push_back(bus_wdata[7:0]);
      end
      if (!lon || !ron || md != 2) m_scan = 0;
      else if (fin && wrp) m_scan = 0;
      else if (st && ext_ok) m_scan = 1;
      if (fin) m_active = 0; else if (st) m_active = 1;
      m_hf = hfs || (m_hf && !clr);
      m_ext = (m_c1[9] && ext_trig) || (m_ext && !clr);
      if (bus_wr && bus_addr == 0) m_c1 = bus_wdata;
      if (bus_wr && bus_addr == 1) m_c2 = bus_wdata;
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_c1;
      2'd1: return m_c2;
      2'd2: return {6'b0, m_ext, m_hf, 3'b0, m_res.size() == RD, m_res.size() >= RD / 2,
                    m_res.size() == 0, m_list.size() == LD, m_active};
      default: return m_res.size() > 0 ? 16'(m_res[0]) : 16'h0;
    endcase
  endfunction

  // converter model
  int lat_cnt = 0;
  int samp = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (!conv_req) lat_cnt = 0;
    else begin
      lat_cnt++;
      if (lat_cnt == LAT) begin
        conv_done = 1'b1;
        conv_result = {4'(samp), conv_diff, conv_unipolar, conv_gain, conv_chan};
        samp++;
        lat_cnt = 0;
      end
    end
  end

  // per-cycle comparison with the model
  logic [7:0] started[$];
  bit prev_req = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(conv_req == m_active, "R4 request", int'(conv_req), int'(m_active));
      chk(irq == (m_c1[15] && (m_hf || m_ext)), "R10 irq", int'(irq),
          int'(m_c1[15] && (m_hf || m_ext)));
      if (conv_req && m_ptr < m_list.size())
        chk({conv_diff, conv_unipolar, conv_gain, conv_chan} == m_list[m_ptr], "R3 select",
            int'({conv_diff, conv_unipolar, conv_gain, conv_chan}), int'(m_list[m_ptr]));
      if (bus_rd)
        chk(bus_rdata == m_read(bus_addr), bus_addr == 3 ? "R8 data" :
            (bus_addr == 2 ? "R9 status" : "R1 control"), int'(bus_rdata),
            int'(m_read(bus_addr)));
      if (conv_req && !prev_req) started.push_back({conv_diff, conv_unipolar, conv_gain, conv_chan});
      prev_req = conv_req;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #2;
      if (!conv_req && !m_scan) break;
    end
  endtask

  task automatic soft_conv(input int n);
    logic [15:0] d;
    for (int i = 0; i < n; i++) begin
      bus_read(2'd0, d);
      wait_idle();
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [15:0] rv;
  int n0;
  logic [7:0] exp_e[4];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_read(2'd2, rv); chk(rv == 16'h0004, "R1 status", rv, 16'h0004);
    bus_read(2'd0, rv); chk(rv == 16'h0000, "R1 ctrlA", rv, 0);
    bus_read(2'd1, rv); chk(rv == 16'h0000, "R1 ctrlB", rv, 0);

    bus_write(2'd1, 16'h0600);
    bus_write(2'd3, 16'h0085);
    bus_write(2'd3, 16'h003A);
    bus_write(2'd3, 16'h004F);
    // R2 software trigger, R3 fields, R5 wrap
    bus_write(2'd0, 16'h0001);
    n0 = started.size();
    soft_conv(4);
    chk(started.size() == n0 + 4, "R2 soft starts", started.size() - n0, 4);
    exp_e = '{8'h85, 8'h3A, 8'h4F, 8'h85};
    if (started.size() == n0 + 4) begin
      chk(started[n0] == 8'h85, "R3 first entry", started[n0], 8'h85);
      for (int i = 0; i < 4; i++)
        chk(started[n0 + i] == exp_e[i], "R5 order", started[n0 + i], exp_e[i]);
    end
    bus_read(2'd2, rv); chk(rv == 16'h0000, "R9 four held", rv, 0);
    // R8 readout
    for (int i = 0; i < 4; i++) begin
      bus_read(2'd3, rv);
      chk(rv[15:12] == 4'h0, "R8 upper zero", rv[15:12], 0);
      chk(rv[7:0] == exp_e[i], "R8 order", rv[7:0], exp_e[i]);
    end
    bus_read(2'd3, rv); chk(rv == 16'h0, "R8 empty read", rv, 0);
    bus_read(2'd2, rv); chk(rv == 16'h0004, "R8 still empty", rv, 16'h0004);

    // R2 mode 0 ignores control reads
    bus_write(2'd0, 16'h0000);
    n0 = started.size();
    bus_read(2'd0, rv);
    repeat (10) @(negedge clk);
    chk(started.size() == n0, "R2 mode0", started.size() - n0, 0);

    // R6 external single, then scan
    bus_write(2'd0, 16'h0003);
    n0 = started.size();
    pulse_ext(); wait_idle();
    chk(started.size() == n0 + 1, "R6 ext single", started.size() - n0, 1);
    if (started.size() == n0 + 1)
      chk(started[n0] == 8'h3A, "R6 ext entry", started[n0], 8'h3A);
    bus_write(2'd0, 16'h0002);
    n0 = started.size();
    pulse_ext(); wait_idle();
    chk(started.size() == n0 + 1, "R6 scan tail", started.size() - n0, 1);
    n0 = started.size();
    pulse_ext(); wait_idle();
    chk(started.size() == n0 + 3, "R6 full scan", started.size() - n0, 3);
    if (started.size() == n0 + 3)
      chk(started[n0 + 2] == 8'h4F, "R6 scan last", started[n0 + 2], 8'h4F);

    // R7 result FIFO disable flushes and blocks starts
    bus_write(2'd1, 16'h0200);
    bus_write(2'd0, 16'h0001);
    n0 = started.size();
    bus_read(2'd0, rv);
    repeat (10) @(negedge clk);
    chk(started.size() == n0, "R7 no start", started.size() - n0, 0);
    bus_read(2'd2, rv); chk(rv == 16'h0004, "R7 flushed", rv, 16'h0004);
    bus_write(2'd1, 16'h0600);

    // R9 / R10 fill and half-full interrupt
    bus_write(2'd0, 16'h8101);
    soft_conv(7);
    chk(irq == 1'b0, "R10 below half", irq, 0);
    soft_conv(1);
    chk(irq == 1'b1, "R10 half irq", irq, 1);
    bus_read(2'd2, rv); chk(rv == 16'h0108, "R9 half", rv, 16'h0108);
    soft_conv(9);
    bus_read(2'd2, rv); chk(rv == 16'h0118, "R9 full", rv, 16'h0118);
    bus_write(2'd2, 16'h0000);
    chk(irq == 1'b0, "R10 cleared", irq, 0);
    n0 = 0;
    for (int i = 0; i < 20; i++) begin
      bus_read(2'd3, rv);
      if (rv != 16'h0) n0++;
    end
    chk(n0 == 16, "R9 drop on full", n0, 16);

    // R7 list disable, R9 list full
    bus_write(2'd1, 16'h0400);
    bus_write(2'd3, 16'h0011);
    bus_write(2'd1, 16'h0600);
    n0 = started.size();
    bus_read(2'd0, rv);
    repeat (10) @(negedge clk);
    chk(started.size() == n0, "R7 list write ignored", started.size() - n0, 0);
    for (int i = 0; i < 17; i++) bus_write(2'd3, 16'(8'h20 + i));
    bus_read(2'd2, rv); chk(rv == 16'h0006, "R9 list full", rv, 16'h0006);

    // R10 external cause
    bus_write(2'd0, 16'h8200);
    pulse_ext();
    @(negedge clk); #1;
    chk(irq == 1'b1, "R10 ext irq", irq, 1);
    bus_read(2'd2, rv); chk(rv == 16'h0206, "R10 ext flag", rv, 16'h0206);
    bus_write(2'd2, 16'h0000);
    @(negedge clk); #1;
    chk(irq == 1'b0, "R10 ext cleared", irq, 0);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule